// File: doc/BRIEF.md
# Merging Write Buffer with Read-Miss Bypass Check

This block sits between a write-through cache and memory. The processor hands it single-word stores and keeps executing while the buffer sends them to memory in the background. Each entry covers one block: a block address, one data word per word of the block, and one valid bit per word. A store whose block already sits in a waiting entry is folded into that entry, so several stores to the same block cost one memory transfer.

Before a read miss goes to memory, it probes the buffer with its word address. If no pending write touches the block, the miss may proceed at once. If the exact word is held, the buffered data is returned. If the block is held but that word is not, the probe is held off until that entry has been written out. A read miss therefore waits only for a real conflict and never for the whole buffer to drain. Entries leave in allocation order, one per memory handshake.

Back-pressure rules: a store is taken on a cycle where `st_valid` and `st_ready` are both high, and `st_ready` does not depend on `st_valid`. The probe answer (`rd_ready`, `rd_hit`, `rd_data`) is combinational from `rd_addr` and the buffer state. The memory side uses valid/ready: once `mem_valid` is raised, the offered entry stays unchanged until `mem_ready` is seen.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid`=0, `st_ready`=1, `rd_ready`=1, `rd_hit`=0, `rd_data`=0.
- R2: A store to a block held by no entry, with a free entry available, is accepted. It opens a new entry at the youngest position in which only the addressed word is valid. Words not written in that entry read as zero.
- R3: A store to a block held by any entry except the oldest is accepted and merged into that entry. It overwrites that word, sets that word's valid bit and opens no new entry.
- R4: `st_ready` is 0 when the store's block matches the oldest entry (the one offered to memory). It is also 0 when no entry matches and all ENTRIES entries are occupied. It never depends on `mem_ready` in the same cycle.
- R5: A probe whose block is held by no entry gives `rd_ready`=1, `rd_hit`=0 and `rd_data`=0.
- R6: A probe whose word is valid in a held entry gives `rd_ready`=1, `rd_hit`=1 and `rd_data` equal to the most recently stored data for that word.
- R7: A probe whose block is held but whose word valid bit is clear gives `rd_ready`=0 and `rd_hit`=0 until that entry has left the buffer.
- R8: While any entry is held, `mem_valid`=1 and the oldest entry is offered. `mem_addr` is its block address (word address divided by WORDS). Bit i of `mem_mask` and slice i of `mem_data` (bits i*DATA_W upward) belong to word i. The offer stays stable while `mem_ready` is low.
- R9: Exactly one entry, the oldest, is removed on each cycle with `mem_valid` and `mem_ready` high. A store may open an entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be taken |
| st_addr | input | ADDR_W | Store word address; low log2(WORDS) bits pick the word |
| st_data | input | DATA_W | Store data |
| rd_addr | input | ADDR_W | Read-miss probe word address |
| rd_ready | output | 1 | Probe may proceed (no partial conflict) |
| rd_hit | output | 1 | Probed word is held in the buffer |
| rd_data | output | DATA_W | Buffered word when `rd_hit`, else zero |
| mem_valid | output | 1 | An entry is offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_addr | output | ADDR_W-log2(WORDS) | Block address of the offered entry |
| mem_mask | output | WORDS | Per-word valid bits of the offered entry |
| mem_data | output | WORDS*DATA_W | Word data of the offered entry |

## Verification
The first directed pattern fills the buffer with memory stalled. It mixes fresh blocks, merges into younger entries, a store to the offered block and a store into a full buffer, which separates merge from allocation and both stall causes. Probes during that phase cover an absent block, a held word and a held block with a missing word, which separates pass-through, bypass and conflict stall. A drain phase with memory always ready shows the release order. A long random phase then uses a small block-address range, random memory back-pressure and concurrent stores, probes and drains. It catches mistakes in same-cycle allocate-and-remove and in pointer wrap.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Circular successor of a slot number within a ring of n slots.
  function automatic int ring_next(input int p, input int n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

  // Index width that is at least one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wbuf_lookup.sv
module wbuf_lookup #(
  parameter int N     = 4,
  parameter int TAG_W = 14,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]            occ,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            match_vec,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);

  // Parallel tag compare across every slot.
  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign match_vec[e] = occ[e] && (tags[e] == key);
  end

  assign hit = |match_vec;

  // Blocks are unique in the buffer, so a plain encoder suffices.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/wbuf_entries.sv
module wbuf_entries #(
  parameter int N      = 4,
  parameter int TAG_W  = 14,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                st_fire,
  input  logic                                st_alloc,
  input  logic [IDX_W-1:0]                    st_merge_idx,
  input  logic [TAG_W-1:0]                    st_tag,
  input  logic [OFF_W-1:0]                    st_word,
  input  logic [DATA_W-1:0]                   st_data,
  input  logic                                pop,
  output logic [N-1:0]                        occ,
  output logic [N-1:0][TAG_W-1:0]             tags,
  output logic [N-1:0][WORDS-1:0]             mask,
  output logic [N-1:0][WORDS-1:0][DATA_W-1:0] data,
  output logic [IDX_W-1:0]                    head,
  output logic [CNT_W-1:0]                    count
);
  import wbuf_pkg::*;

  logic [IDX_W-1:0] tail;
  logic             do_alloc;
  logic             do_merge;

  assign do_alloc = st_fire && st_alloc;
  assign do_merge = st_fire && !st_alloc;

  for (genvar e = 0; e < N; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[e]  <= 1'b0;
        tags[e] <= '0;
        mask[e] <= '0;
        data[e] <= '0;
      end else begin
        if (pop && head == IDX_W'(e)) occ[e] <= 1'b0;
        if (do_alloc && tail == IDX_W'(e)) begin
          occ[e]  <= 1'b1;
          tags[e] <= st_tag;
          for (int w = 0; w < WORDS; w++) begin
            mask[e][w] <= (st_word == OFF_W'(w));
            data[e][w] <= (st_word == OFF_W'(w)) ? st_data : '0;
          end
        end else if (do_merge && st_merge_idx == IDX_W'(e)) begin
          mask[e][st_word] <= 1'b1;
          data[e][st_word] <= st_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop)      head <= IDX_W'(ring_next(int'(head), N));
      if (do_alloc) tail <= IDX_W'(ring_next(int'(tail), N));
      case ({do_alloc, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_ready,
  output logic                    rd_hit,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [TAG_W-1:0]        mem_addr,
  output logic [WORDS-1:0]        mem_mask,
  output logic [WORDS*DATA_W-1:0] mem_data
);
  import wbuf_pkg::*;

  localparam int IDX_W = idx_bits(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0]                        occ;
  logic [ENTRIES-1:0][TAG_W-1:0]             tags;
  logic [ENTRIES-1:0][WORDS-1:0]             mask;
  logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0] data;
  logic [IDX_W-1:0]                          head;
  logic [CNT_W-1:0]                          count;

  logic [TAG_W-1:0]   st_tag, rd_tag;
  logic [OFF_W-1:0]   st_word, rd_word;
  logic [ENTRIES-1:0] s_vec, r_vec;
  logic               s_hit, r_hit;
  logic [IDX_W-1:0]   s_idx, r_idx;
  logic               st_fire, pop, full, word_held;

  assign st_tag  = st_addr[ADDR_W-1:OFF_W];
  assign st_word = st_addr[OFF_W-1:0];
  assign rd_tag  = rd_addr[ADDR_W-1:OFF_W];
  assign rd_word = rd_addr[OFF_W-1:0];

  wbuf_lookup #(.N(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_st_look (
    .occ(occ), .tags(tags), .key(st_tag),
    .match_vec(s_vec), .hit(s_hit), .idx(s_idx)
  );

  wbuf_lookup #(.N(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_rd_look (
    .occ(occ), .tags(tags), .key(rd_tag),
    .match_vec(r_vec), .hit(r_hit), .idx(r_idx)
  );

  // Store admission: merge anywhere but the offered entry, else need room.
  assign full     = (count == CNT_W'(ENTRIES));
  assign st_ready = s_hit ? (s_idx != head) : !full;
  assign st_fire  = st_valid && st_ready;

  // Memory side: oldest entry is always the one on offer.
  assign mem_valid = occ[head];
  assign mem_addr  = tags[head];
  assign mem_mask  = mask[head];
  assign mem_data  = data[head];
  assign pop       = mem_valid && mem_ready;

  // Read-miss probe: pass, bypass, or hold off on a partial conflict.
  assign word_held = r_hit && mask[r_idx][rd_word];
  assign rd_ready  = !r_hit || word_held;
  assign rd_hit    = word_held;
  assign rd_data   = word_held ? data[r_idx][rd_word] : '0;

  wbuf_entries #(
    .N(ENTRIES), .TAG_W(TAG_W), .WORDS(WORDS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_entries (
    .clk(clk), .rst_n(rst_n),
    .st_fire(st_fire), .st_alloc(!s_hit), .st_merge_idx(s_idx),
    .st_tag(st_tag), .st_word(st_word), .st_data(st_data),
    .pop(pop),
    .occ(occ), .tags(tags), .mask(mask), .data(data),
    .head(head), .count(count)
  );

  // R8: the offer is frozen while memory back-pressures.
  a_r8_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                              && $stable(mem_mask) && $stable(mem_data));

  // R3: merging keeps every block in at most one entry.
  a_r3_unique_block: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_vec) && $onehot0(r_vec));

  // R6: a bypass hit is never a stalled probe.
  a_r6_hit_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_ready);

  // R2: a fresh allocation without a drain grows the occupancy by one.
  a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && !s_hit && !pop |=> count == $past(count) + 1'b1);

  // R9: occupancy moves by at most one per cycle and never exceeds the size.
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && s_hit && pop |=> count == $past(count) - 1'b1);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full && !s_hit |-> !st_ready);

endmodule

// File: tb/merge_wbuf_tb_top.sv
module merge_wbuf_tb_top;
  localparam int N  = 4;
  localparam int WD = 4;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int TW = AW - 2;

  typedef struct packed {
    logic [TW-1:0]          tag;
    logic [WD-1:0][DW-1:0]  d;
    logic [WD-1:0]          m;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic mem_ready = 1'b0;
  logic st_ready, rd_ready, rd_hit, mem_valid;
  logic [DW-1:0] rd_data;
  logic [TW-1:0] mem_addr;
  logic [WD-1:0] mem_mask;
  logic [WD*DW-1:0] mem_data;

  always #2.5 clk = ~clk;

  merge_wbuf #(.ENTRIES(N), .WORDS(WD), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_hit(rd_hit), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_mask(mem_mask), .mem_data(mem_data)
  );

  ent_t q[$];
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [WD*DW-1:0] act, input logic [WD*DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find(input logic [TW-1:0] t);
    for (int i = 0; i < q.size(); i++) if (q[i].tag == t) return i;
    return -1;
  endfunction

  // One cycle: drive at negedge, compare model, update model at posedge.
  task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic [AW-1:0] ra, input bit mr);
    int si, ri;
    bit exp_st, wv, fire, pp;
    string sreq, rreq;
    ent_t ne;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; rd_addr = ra; mem_ready = mr;
    #1;
    si = find(sa[AW-1:2]);
    ri = find(ra[AW-1:2]);
    exp_st = (si >= 0) ? (si != 0) : (q.size() < N);
    sreq = (si == 0 || (si < 0 && q.size() == N)) ? "R4" : (si > 0 ? "R3" : "R2");
    wv = (ri >= 0) && q[ri].m[ra[1:0]];
    rreq = (ri < 0) ? "R5" : (wv ? "R6" : "R7");
    check(sreq, "st_ready", {127'd0, st_ready}, {127'd0, exp_st});
    check(rreq, "rd_ready", {127'd0, rd_ready}, {127'd0, (ri < 0) || wv});
    check(rreq, "rd_hit", {127'd0, rd_hit}, {127'd0, wv});
    check(rreq, "rd_data", {96'd0, rd_data}, {96'd0, wv ? q[ri].d[ra[1:0]] : 32'd0});
    check("R9", "mem_valid", {127'd0, mem_valid}, {127'd0, q.size() > 0});
    if (q.size() > 0) begin
      check("R8", "mem_addr", {114'd0, mem_addr}, {114'd0, q[0].tag});
      check("R8", "mem_mask", {124'd0, mem_mask}, {124'd0, q[0].m});
      check("R8", "mem_data", mem_data, q[0].d);
    end
    fire = sv && exp_st;
    pp = (q.size() > 0) && mr;
    @(posedge clk);
    if (fire && si > 0) begin
      q[si].m[sa[1:0]] = 1'b1;
      q[si].d[sa[1:0]] = sd;
    end
    if (pp) void'(q.pop_front());
    if (fire && si < 0) begin
      ne = '0;
      ne.tag = sa[AW-1:2];
      ne.m[sa[1:0]] = 1'b1;
      ne.d[sa[1:0]] = sd;
      q.push_back(ne);
    end
  endtask

  function automatic logic [AW-1:0] wa(input int blk, input int w);
    return AW'(blk * WD + w);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "mem_valid", {127'd0, mem_valid}, 128'd0);
    check("R1", "st_ready", {127'd0, st_ready}, 128'd1);
    check("R1", "rd_ready", {127'd0, rd_ready}, 128'd1);
    check("R1", "rd_hit", {127'd0, rd_hit}, 128'd0);
    check("R1", "rd_data", {96'd0, rd_data}, 128'd0);

    // Fill with memory stalled: allocate, merge, head clash, full.
    step(1, wa(1, 0), 32'hA0, wa(1, 0), 0);  // R2 alloc, R5 probe
    step(1, wa(2, 1), 32'hB1, wa(1, 0), 0);  // R2, R6 bypass
    step(1, wa(2, 3), 32'hB3, wa(1, 2), 0);  // R3 merge, R7 partial
    step(1, wa(1, 2), 32'hA2, wa(2, 3), 0);  // R4 head clash, R6
    step(1, wa(3, 0), 32'hC0, wa(2, 0), 0);  // R2, R7
    step(1, wa(4, 0), 32'hD0, wa(5, 0), 0);  // R2 fills, R5
    step(1, wa(5, 0), 32'hE0, wa(4, 0), 0);  // R4 full stall
    step(1, wa(2, 1), 32'hB9, wa(2, 1), 0);  // R3 overwrite
    step(0, '0, '0, wa(2, 1), 0);            // R6 newest data
    step(1, wa(5, 1), 32'hE1, wa(1, 1), 1);  // R4 while draining, R9 pop
    // Drain in order.
    for (int i = 0; i < 6; i++) step(0, '0, '0, wa(3, 1), 1);

    // Random traffic over a small block range.
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) != 0, wa($urandom_range(0, 6), $urandom_range(0, 3)),
           $urandom, wa($urandom_range(0, 6), $urandom_range(0, 3)),
           $urandom_range(0, 2) == 0);
    for (int i = 0; i < 8; i++) step(0, '0, '0, '0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule